// File: doc/BRIEF.md
# Level-Sensitive Main Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines for a processor and routes them to three interrupt outputs: a normal interrupt, a fast interrupt and an endpoint interrupt. A single shared cause view shows the live level of every request line. Each output has its own enable mask, so any source can be steered to any mix of the three outputs. Each output is the OR of the request lines that its own mask enables, and it is registered for one clock.

Software reaches the block through a small register bus with a single-cycle write strobe and a read strobe whose data appears on the following cycle. The cause word is read-only and follows the inputs without latching them. A status word spares the interrupt handler a bit scan. It reports whether any source enabled for the normal output is pending, and gives the number of the highest such source.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all three mask registers hold zero, every interrupt output is low and the read data is zero.
- R2: A read strobe at byte offset 0x00 returns the request-line levels sampled at the clock edge of the strobe, with bit n holding source n. The data is on `bus_rdata` from the next cycle. Cause bits are not latched, so a line that falls reads back as 0.
- R3: A write to offset 0x00 or to the status offset 0x10 changes no mask and no output.
- R4: A write strobe at offset 0x04 (normal mask), 0x08 (fast mask) or 0x0c (endpoint mask) loads that mask from `bus_wdata` at the strobe edge, and a read at the same offset returns it. A mask bit of 1 enables its source and a bit of 0 blocks it.
- R5: `irq_norm` equals the OR over all bits of (request AND normal mask), taken at the previous clock edge.
- R6: `irq_fast` equals the OR over all bits of (request AND fast mask), taken at the previous clock edge.
- R7: `irq_endp` equals the OR over all bits of (request AND endpoint mask), taken at the previous clock edge.
- R8: A read at offset 0x10 returns a status word. Bit 31 is 1 when (request AND normal mask) is nonzero, and bits 4:0 give the highest bit number set in it. The whole word is zero when nothing is pending.
- R9: A read at any other offset returns zero, and a write there changes nothing. When no read strobe is given, `bus_rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_lvl | input | 32 | Level-sensitive request lines, one per source |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_norm | output | 1 | Normal interrupt output |
| irq_fast | output | 1 | Fast interrupt output |
| irq_endp | output | 1 | Endpoint interrupt output |

## Verification
The bench aims at the edges of the priority index: only source 0 pending, only source 31 pending, and many bits pending with the normal mask picking a subset. An encoder that scans from the wrong end, or that scans raw requests instead of enabled ones, would report the wrong index or a false valid bit. Writes to the cause and status offsets are mixed into random traffic, so a decoder that lets them reach a mask would later raise an output that should stay low. Sources enabled in only one mask check that the three outputs never pick up another output's mask.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_lvl,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_norm,
  output logic            irq_fast,
  output logic            irq_endp
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] OFS_CAUSE = AW'(5'h00);
  localparam logic [AW-1:0] OFS_NORM  = AW'(5'h04);
  localparam logic [AW-1:0] OFS_FAST  = AW'(5'h08);
  localparam logic [AW-1:0] OFS_ENDP  = AW'(5'h0c);
  localparam logic [AW-1:0] OFS_STAT  = AW'(5'h10);

  logic [NSRC-1:0] msk_norm, msk_fast, msk_endp;
  logic [NSRC-1:0] pend_norm;
  logic [IW-1:0]   top_idx;
  logic [DW-1:0]   stat_word, rd_mux;

  assign pend_norm = req_lvl & msk_norm;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_norm[i]) top_idx = IW'(i);
  end

  always_comb begin
    stat_word = '0;
    stat_word[DW-1] = |pend_norm;
    stat_word[IW-1:0] = top_idx;
  end

  always_comb begin
    case (bus_addr)
      OFS_CAUSE: rd_mux = DW'(req_lvl);
      OFS_NORM:  rd_mux = DW'(msk_norm);
      OFS_FAST:  rd_mux = DW'(msk_fast);
      OFS_ENDP:  rd_mux = DW'(msk_endp);
      OFS_STAT:  rd_mux = stat_word;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_norm <= '0;
      msk_fast <= '0;
      msk_endp <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_NORM) msk_norm <= bus_wdata[NSRC-1:0];
      if (bus_addr == OFS_FAST) msk_fast <= bus_wdata[NSRC-1:0];
      if (bus_addr == OFS_ENDP) msk_endp <= bus_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_norm  <= 1'b0;
      irq_fast  <= 1'b0;
      irq_endp  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_norm <= |pend_norm;
      irq_fast <= |(req_lvl & msk_fast);
      irq_endp <= |(req_lvl & msk_endp);
    end
  end

  AST_RST_MASKS: assert property (@(posedge clk) !rst_n |=> (msk_norm == '0 && msk_fast == '0 && msk_endp == '0)); // R1
  AST_CAUSE_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && bus_addr == OFS_CAUSE) |=> bus_rdata == DW'($past(req_lvl))); // R2
  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && (bus_addr == OFS_CAUSE || bus_addr == OFS_STAT)) |=> ($stable(msk_norm) && $stable(msk_fast) && $stable(msk_endp))); // R3
  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (req_lvl == '0) |=> (!irq_norm && !irq_fast && !irq_endp)); // R5
  AST_STAT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && bus_addr == OFS_STAT && msk_norm == '0) |=> bus_rdata == '0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_lvl = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_norm, irq_fast, irq_endp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_norm = '0, m_fast = '0, m_endp = '0, m_rdata = '0;

  lvl_irq_ctrl uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_stat(input logic [31:0] p);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++)
      if (p[i]) begin w[31] = 1'b1; w[4:0] = 5'(i); end
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a, input logic [31:0] r);
    case (a)
      5'h00: return r;
      5'h04: return m_norm;
      5'h08: return m_fast;
      5'h0c: return m_endp;
      5'h10: return exp_stat(r & m_norm);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] r, input int op, input logic [4:0] a, input logic [31:0] d);
    logic xn, xf, xe;
    req_lvl = r; bus_addr = a; bus_wdata = d;
    bus_rd = (op == 1); bus_wr = (op == 2);
    xn = |(r & m_norm); xf = |(r & m_fast); xe = |(r & m_endp);
    if (op == 1) m_rdata = exp_read(a, r);
    @(posedge clk); #1;
    if (op == 2) begin
      if (a == 5'h04) m_norm = d;
      if (a == 5'h08) m_fast = d;
      if (a == 5'h0c) m_endp = d;
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    chk("R5 irq_norm", 32'(irq_norm), 32'(xn));
    chk("R6 irq_fast", 32'(irq_fast), 32'(xf));
    chk("R7 irq_endp", 32'(irq_endp), 32'(xe));
    chk("R2/R4/R8/R9 rdata", bus_rdata, m_rdata);
  endtask

  initial begin
    void'($urandom(32'd1234));
    req_lvl = 32'hffff_ffff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 outputs", {29'h0, irq_norm, irq_fast, irq_endp}, 32'h0);
    rst_n = 1'b1;
    step(32'hffff_ffff, 0, 5'h0, 0);
    chk("R1 masks block all", {29'h0, irq_norm, irq_fast, irq_endp}, 32'h0);
    step(32'hffff_ffff, 1, 5'h04, 0);
    step(32'hffff_ffff, 1, 5'h08, 0);
    step(32'hffff_ffff, 1, 5'h0c, 0);
    // R3: writes to read-only offsets
    step(32'h0, 2, 5'h00, 32'hffff_ffff);
    step(32'h0, 2, 5'h10, 32'hffff_ffff);
    step(32'hffff_ffff, 1, 5'h04, 0);
    chk("R3 norm mask untouched", bus_rdata, 32'h0);
    step(32'hffff_ffff, 0, 5'h0, 0);
    chk("R3 no output", {29'h0, irq_norm, irq_fast, irq_endp}, 32'h0);
    // R2: cause is live
    step(32'h8000_0001, 1, 5'h00, 0);
    chk("R2 cause", bus_rdata, 32'h8000_0001);
    step(32'h0000_0001, 1, 5'h00, 0);
    chk("R2 cause not latched", bus_rdata, 32'h0000_0001);
    // R8 index corners
    step(32'h0, 2, 5'h04, 32'hffff_ffff);
    step(32'h0000_0001, 1, 5'h10, 0);
    chk("R8 only src0", bus_rdata, 32'h8000_0000);
    step(32'h8000_0000, 1, 5'h10, 0);
    chk("R8 only src31", bus_rdata, 32'h8000_001f);
    step(32'h0, 2, 5'h04, 32'h0000_0f00);
    step(32'hf000_ff0f, 1, 5'h10, 0);
    chk("R8 masked subset", bus_rdata, 32'h8000_000b);
    // R6/R7 separation
    step(32'h0, 2, 5'h04, 32'h0);
    step(32'h0, 2, 5'h08, 32'h0000_0010);
    step(32'h0, 2, 5'h0c, 32'h0000_0020);
    step(32'h0000_0010, 0, 5'h0, 0);
    chk("R6 fast only", {29'h0, irq_norm, irq_fast, irq_endp}, 32'h2);
    step(32'h0000_0020, 0, 5'h0, 0);
    chk("R7 endp only", {29'h0, irq_norm, irq_fast, irq_endp}, 32'h1);
    // R9 unmapped
    step(32'h0, 2, 5'h14, 32'hffff_ffff);
    step(32'hffff_ffff, 1, 5'h14, 0);
    chk("R9 unmapped reads zero", bus_rdata, 32'h0);
    step(32'hffff_ffff, 1, 5'h08, 0);
    chk("R4 fast readback", bus_rdata, 32'h0000_0010);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r, d;
      int op;
      logic [4:0] a;
      r = $urandom();
      if ($urandom_range(3) == 0) r = r & $urandom() & $urandom();
      op = $urandom_range(2);
      a = 5'($urandom_range(8) * 4);
      if ($urandom_range(7) == 0) a = 5'($urandom());
      d = $urandom() & $urandom();
      step(r, op, a, d);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule